// File: doc/BRIEF.md
# Dual-Edge Heartbeat Watchdog

This block supervises a processor by watching a heartbeat line that software toggles while it runs normally. The heartbeat is asynchronous to the block's clock, so it first passes through a synchroniser. Any change of the synchronised level, rising or falling, restarts a cycle counter. If the counter reaches the configured timeout without a further change, the active-low alarm output goes low. The alarm is intended to drive a nonmaskable interrupt.

Two inputs from a supply supervisor take precedence over the counter. The first is a supervisor reset. While it is high, the counter is held at zero and no timeout alarm is shown, so a processor in reset is never interrupted. Counting starts again from zero once that reset goes away. The second is a supply-low flag, which pulls the alarm low whatever the counter or the supervisor reset is doing.

The timeout is a parameter in clock cycles. At a 250 MHz clock, the default equals a nominal 1.6 s. The counter stops at the timeout value and does not wrap.

Top module: `hb_watchdog`

## Requirements
- R1: With no heartbeat change and supervisor reset and supply-low both low, `wdo_no` goes low exactly `TIMEOUT_CYC` clock edges after the edge that last cleared the counter.
- R2: A rising change of `beat_i` clears the counter. The clear takes effect on the third clock edge after the change is sampled, made up of two synchroniser stages and one counter register.
- R3: A falling change of `beat_i` clears the counter with the same three-edge latency. A heartbeat that changes at least once every `TIMEOUT_CYC` cycles never produces an alarm. A gap of `TIMEOUT_CYC+1` cycles produces one.
- R4: While `sup_rst_i` is high, the counter is held at zero. `wdo_no` is high on the following edge unless supply-low is active. After release, the alarm appears `TIMEOUT_CYC` edges later if there is no heartbeat.
- R5: `supply_low_i` high forces `wdo_no` low on the next clock edge, regardless of the counter and of `sup_rst_i`. Removing it lets the output return high on the next edge if no timeout is pending.
- R6: A heartbeat pulse one clock cycle wide is seen as two changes, and each change clears the counter. The final clear is one cycle after the first.
- R7: After a timeout, the next heartbeat change brings `wdo_no` back high three edges after it is sampled, and the counter restarts from zero.
- R8: Once expired, the counter holds at `TIMEOUT_CYC` without wrapping, so `wdo_no` stays low for as long as no heartbeat change or supervisor reset occurs.
- R9: While `arst_ni` is low, `wdo_no` is high and the counter and synchroniser are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| arst_ni | input | 1 | Asynchronous block reset, active low |
| beat_i | input | 1 | Heartbeat from the processor, asynchronous |
| sup_rst_i | input | 1 | Supervisor reset, active high, synchronous to clk_i |
| supply_low_i | input | 1 | Supply-low flag, active high, synchronous to clk_i |
| wdo_no | output | 1 | Watchdog alarm, active low (0 = alarm) |

## Verification
The bench sweeps the heartbeat period from one cycle to two past the timeout. A counter that is off by one at either end would either raise an alarm for a period of exactly `TIMEOUT_CYC` or miss the alarm at `TIMEOUT_CYC+1`. Single-cycle pulses are used to show that both edges clear the counter; a design that only cleared on rising edges would alarm one cycle early. Long idle stretches check that a wrapping counter, which would release the alarm by itself, does not. A long pseudo-random mix of heartbeat, supervisor reset and supply-low is compared each cycle against an arithmetic model, which exposes any wrong priority between reset, supply-low and timeout.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Alarm output levels (active low)
    localparam logic WDO_FIRE  = 1'b0;
    localparam logic WDO_QUIET = 1'b1;

    // Counter action chosen each cycle
    typedef enum logic [1:0] {
        CNT_CLEAR = 2'd0,
        CNT_STEP  = 2'd1,
        CNT_HOLD  = 2'd2
    } cnt_op_e;

endpackage

// File: rtl/wdt_beat_sync.sv
module wdt_beat_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic arst_ni,
    input  logic beat_i,
    output logic change_o
);
    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    generate
        if (STAGES >= 2) begin : g_multi
            always_comb begin
                s_d       = s_q;
                s_d.chain = {s_q.chain[STAGES-2:0], beat_i};
                s_d.prev  = s_q.chain[LAST];
            end
        end else begin : g_single
            always_comb begin
                s_d       = s_q;
                s_d.chain = beat_i;
                s_d.prev  = s_q.chain[LAST];
            end
        end
    endgenerate

    always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) s_q <= '0;
        else          s_q <= s_d;
    end

    assign change_o = s_q.chain[LAST] ^ s_q.prev;

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 400_000_000
) (
    input  logic clk_i,
    input  logic arst_ni,
    input  logic change_i,
    input  logic clear_i,
    output logic expired_nxt_o
);
    localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_t;

    cnt_t    c_d, c_q;
    cnt_op_e op;

    always_comb begin
        if (clear_i || change_i)   op = CNT_CLEAR;
        else if (c_q.cnt == LIMIT) op = CNT_HOLD;
        else                       op = CNT_STEP;

        c_d = c_q;
        unique case (op)
            CNT_CLEAR: c_d.cnt = '0;
            CNT_STEP:  c_d.cnt = c_q.cnt + 1'b1;
            default:   c_d.cnt = c_q.cnt;
        endcase
    end

    always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) c_q <= '0;
        else          c_q <= c_d;
    end

    assign expired_nxt_o = (c_d.cnt == LIMIT);

    // R2 R3
    edge_clear_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
        change_i |=> (c_q.cnt == '0));

    // R4
    rst_hold_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
        clear_i |=> (c_q.cnt == '0));

    // R8
    no_wrap_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
        (c_q.cnt == LIMIT && !change_i && !clear_i) |=> (c_q.cnt == LIMIT));

    // R1
    count_step_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
        (c_q.cnt != LIMIT && !change_i && !clear_i) |=>
        (c_q.cnt == $past(c_q.cnt) + 1'b1));

endmodule

// File: rtl/wdt_alarm_out.sv
module wdt_alarm_out
    import wdt_pkg::*;
(
    input  logic clk_i,
    input  logic arst_ni,
    input  logic expired_nxt_i,
    input  logic sup_rst_i,
    input  logic supply_low_i,
    output logic wdo_no
);
    typedef struct packed {
        logic wdo;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d = o_q;
        if (supply_low_i)       o_d.wdo = WDO_FIRE;
        else if (sup_rst_i)     o_d.wdo = WDO_QUIET;
        else if (expired_nxt_i) o_d.wdo = WDO_FIRE;
        else                    o_d.wdo = WDO_QUIET;
    end

    always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) o_q <= '{wdo: WDO_QUIET};
        else          o_q <= o_d;
    end

    assign wdo_no = o_q.wdo;

    // R5
    low_force_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
        supply_low_i |=> (wdo_no == WDO_FIRE));

    // R4
    rst_quiet_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
        (sup_rst_i && !supply_low_i) |=> (wdo_no == WDO_QUIET));

endmodule

// File: rtl/hb_watchdog.sv
module hb_watchdog
    import wdt_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 400_000_000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic arst_ni,
    input  logic beat_i,
    input  logic sup_rst_i,
    input  logic supply_low_i,
    output logic wdo_no
);
    logic change;
    logic expired_nxt;

    wdt_beat_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i    (clk_i),
        .arst_ni  (arst_ni),
        .beat_i   (beat_i),
        .change_o (change)
    );

    wdt_counter #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_cnt (
        .clk_i         (clk_i),
        .arst_ni       (arst_ni),
        .change_i      (change),
        .clear_i       (sup_rst_i),
        .expired_nxt_o (expired_nxt)
    );

    wdt_alarm_out u_out (
        .clk_i         (clk_i),
        .arst_ni       (arst_ni),
        .expired_nxt_i (expired_nxt),
        .sup_rst_i     (sup_rst_i),
        .supply_low_i  (supply_low_i),
        .wdo_no        (wdo_no)
    );

    // R7
    recover_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
        (change && !supply_low_i) |=> (wdo_no == WDO_QUIET));

endmodule

// File: tb/tb_hb_watchdog.sv
module tb_hb_watchdog;
    localparam int T = 12;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic beat = 1'b0;
    logic rst = 1'b0;
    logic low = 1'b0;
    logic wdo;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    hb_watchdog #(.TIMEOUT_CYC(T), .SYNC_STAGES(2)) dut (
        .clk_i(clk), .arst_ni(arst_n), .beat_i(beat),
        .sup_rst_i(rst), .supply_low_i(low), .wdo_no(wdo)
    );

    // arithmetic reference built from the requirements
    logic m1 = 0, m2 = 0, m3 = 0;
    int   age = 0;
    logic exp_wdo = 1'b1;
    always @(posedge clk) begin
        if (!arst_n) begin
            m1 = 0; m2 = 0; m3 = 0; age = 0; exp_wdo = 1'b1;
        end else begin
            logic e;
            e  = (m2 != m3);
            m3 = m2; m2 = m1; m1 = beat;
            if (rst || e)    age = 0;
            else if (age < T) age = age + 1;
            exp_wdo = !low && (rst || age != T);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (arst_n && !done)
            chk(wdo === exp_wdo, "model(R1 R4 R5)", int'(wdo), int'(exp_wdo));
    end

    task automatic wait_level(input logic lvl, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (wdo !== lvl && n < 200);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        bit ok;
        bit saw_low;
        logic [15:0] lfsr;

        repeat (3) @(negedge clk);
        chk(wdo === 1'b1, "R9 reset level", int'(wdo), 1);
        arst_n = 1'b1;

        wait_level(1'b0, n);
        chk(n == T, "R1 timeout cycles", n, T);

        ok = 1;
        for (int i = 0; i < 3 * T; i++) begin
            @(negedge clk);
            if (wdo !== 1'b0) ok = 0;
        end
        chk(ok, "R8 held low no wrap", int'(wdo), 0);

        beat = 1'b1;
        wait_level(1'b1, n);
        chk(n == 3, "R7 recover after rising", n, 3);
        wait_level(1'b0, n);
        chk(n == T, "R2 restart after rising", n, T);

        beat = 1'b0;
        wait_level(1'b1, n);
        chk(n == 3, "R3 recover after falling", n, 3);
        wait_level(1'b0, n);
        chk(n == T, "R3 restart after falling", n, T);

        beat = 1'b1;
        @(negedge clk);
        beat = 1'b0;
        wait_level(1'b1, n);
        chk(n == 2, "R6 pulse first edge", n, 2);
        wait_level(1'b0, n);
        chk(n == T + 1, "R6 pulse second edge", n, T + 1);

        rst = 1'b1;
        @(negedge clk);
        chk(wdo === 1'b1, "R4 reset hides timeout", int'(wdo), 1);
        ok = 1;
        for (int i = 0; i < 3 * T; i++) begin
            @(negedge clk);
            if (wdo !== 1'b1) ok = 0;
        end
        chk(ok, "R4 held high during reset", int'(wdo), 1);
        rst = 1'b0;
        wait_level(1'b0, n);
        chk(n == T, "R4 count after release", n, T);

        rst = 1'b1;
        @(negedge clk);
        low = 1'b1;
        @(negedge clk);
        chk(wdo === 1'b0, "R5 low over reset", int'(wdo), 0);
        low = 1'b0;
        @(negedge clk);
        chk(wdo === 1'b1, "R5 release under reset", int'(wdo), 1);
        rst = 1'b0;
        @(negedge clk);
        low = 1'b1;
        @(negedge clk);
        chk(wdo === 1'b0, "R5 low on healthy timer", int'(wdo), 0);
        low = 1'b0;
        @(negedge clk);
        chk(wdo === 1'b1, "R5 release healthy", int'(wdo), 1);

        for (int p = 1; p <= T + 2; p++) begin
            rst = 1'b1;
            repeat (2) @(negedge clk);
            rst = 1'b0;
            beat = ~beat;
            saw_low = 0;
            for (int k = 0; k < 6; k++) begin
                for (int j = 0; j < p; j++) begin
                    @(negedge clk);
                    if (wdo === 1'b0) saw_low = 1;
                end
                beat = ~beat;
            end
            repeat (2) begin
                @(negedge clk);
                if (wdo === 1'b0) saw_low = 1;
            end
            chk(saw_low == (p > T), $sformatf("R3 R2 keepalive period %0d", p),
                int'(saw_low), int'(p > T));
        end

        lfsr = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[3:0] == 4'd0) beat = ~beat;
            rst = (lfsr[9:5] == 5'd0);
            low = (lfsr[15:11] == 5'd1);
        end
        rst = 1'b0;
        low = 1'b0;
        repeat (2) @(negedge clk);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule